// File: doc/BRIEF.md
# Instruction Prefix and Operand-Select Controller

This block holds the small amount of decode state that a 16-register processor carries between instruction bytes: which register is the source operand, which register is the destination, whether the last prefix was a register-pair select (the B flag), and two mode bits that pick one of four variants of the next instruction. The decoder in front of it classifies each fetched opcode and passes the class, together with the low 4-bit register field, to this controller.

Prefix opcodes (select-both, select-destination, select-source and the three variant prefixes) only change the stored state, and they can be chained. The destination-select and source-select opcodes do a second job. When they directly follow a select-both prefix, and B is therefore set, they become register-to-register moves. The controller then raises a move request naming the two registers for the datapath. When an ordinary instruction or a move completes, every field returns to its idle value. Branches leave the state as it is.

Top module: `pfx_select_ctrl`

## Requirements
- R1: After reset, src_idx and dst_idx are 0, b_flag is 0 and alt_mode is 2'b00.
- R2: A valid op_kind 3'd1 (select-both) with register field n sets src_idx and dst_idx to n and b_flag to 1 from the next cycle on. alt_mode is left unchanged.
- R3: op_kind 3'd2 sets alt_mode bit 0, 3'd3 sets alt_mode bit 1, and 3'd4 sets both bits. Each of the three clears b_flag, leaves the other alt_mode bit as it was, and leaves both indices unchanged.
- R4: op_kind 3'd5 (destination-select) with b_flag clear sets dst_idx to n, leaves every other field unchanged and raises no move request.
- R5: op_kind 3'd5 with b_flag set raises mv_req in the same cycle with mv_src = src_idx, mv_dst = n and mv_flags = 0. In the next cycle all fields are back at their idle values.
- R6: op_kind 3'd6 (source-select) with b_flag clear sets src_idx to n, leaves every other field unchanged and raises no move request.
- R7: op_kind 3'd6 with b_flag set raises mv_req in the same cycle with mv_src = n, mv_dst = dst_idx and mv_flags = 1. In the next cycle all fields are back at their idle values.
- R8: op_kind 3'd0 (ordinary, still executing) and 3'd7 (branch) leave all state unchanged. So does any cycle with op_valid low and op_done low.
- R9: op_done high clears all fields to their idle values in the next cycle: both indices 0, b_flag 0, alt_mode 00.
- R10: When op_done and a valid prefix fall in the same cycle, op_done wins. The prefix has no effect on the state and raises no mv_req.
- R11: mv_req is high only for a valid op_kind 3'd5 or 3'd6 while b_flag is set and op_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | op_kind and reg_field are meaningful this cycle |
| op_kind | input | 3 | Opcode class: 0 ordinary, 1 select-both, 2/3/4 variant prefixes, 5 destination-select, 6 source-select, 7 branch |
| reg_field | input | IDX_W | Register number carried by the opcode |
| op_done | input | 1 | An ordinary instruction completes this cycle |
| src_idx | output | IDX_W | Current source register index |
| dst_idx | output | IDX_W | Current destination register index |
| b_flag | output | 1 | Register-pair select is pending |
| alt_mode | output | 2 | Variant select bits (bit 0 and bit 1) |
| mv_req | output | 1 | Register move requested |
| mv_src | output | IDX_W | Register to read for the move |
| mv_dst | output | IDX_W | Register to write for the move |
| mv_flags | output | 1 | The move also updates the status flags |

## Verification
A corrupted index or mode bit shows on src_idx, dst_idx or alt_mode one cycle after the opcode that should have set it. A stale B flag shows in the same cycle as the next destination-select or source-select, as a wrong mv_req or wrong move operands. A missed clear after completion or after a move leaves nonzero fields visible on the very next cycle. For that reason the bench compares the state after every edge and the move outputs before every edge, using a cycle-accurate reference model, and any divergence is caught within one cycle.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
   typedef enum logic [2:0] {
      K_ORDINARY = 3'd0,
      K_WITH     = 3'd1,
      K_ALT1     = 3'd2,
      K_ALT2     = 3'd3,
      K_ALT3     = 3'd4,
      K_TO       = 3'd5,
      K_FROM     = 3'd6,
      K_BRANCH   = 3'd7
   } op_kind_e;

   localparam int ALT_W = 2;
endpackage

// File: rtl/pfx_next.sv
module pfx_next
   import pfx_pkg::*;
#(
   parameter int IDX_W   = 4,
   parameter int CLR_IDX = 0
) (
   input  logic [IDX_W-1:0] cur_src,
   input  logic [IDX_W-1:0] cur_dst,
   input  logic             cur_b,
   input  logic [ALT_W-1:0] cur_alt,
   input  logic             op_valid,
   input  logic [2:0]       op_kind,
   input  logic [IDX_W-1:0] reg_field,
   input  logic             op_done,
   output logic [IDX_W-1:0] nxt_src,
   output logic [IDX_W-1:0] nxt_dst,
   output logic             nxt_b,
   output logic [ALT_W-1:0] nxt_alt,
   output logic             mv_req_c,
   output logic [IDX_W-1:0] mv_src_c,
   output logic [IDX_W-1:0] mv_dst_c,
   output logic             mv_flags_c
);
   localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(CLR_IDX);

   op_kind_e kind;
   assign kind = op_kind_e'(op_kind);

   always_comb begin
      nxt_src    = cur_src;
      nxt_dst    = cur_dst;
      nxt_b      = cur_b;
      nxt_alt    = cur_alt;
      mv_req_c   = 1'b0;
      mv_src_c   = cur_src;
      mv_dst_c   = cur_dst;
      mv_flags_c = 1'b0;
      if (op_done) begin
         nxt_src = IDLE_IDX;
         nxt_dst = IDLE_IDX;
         nxt_b   = 1'b0;
         nxt_alt = '0;
      end else if (op_valid) begin
         unique case (kind)
            K_WITH: begin
               nxt_src = reg_field;
               nxt_dst = reg_field;
               nxt_b   = 1'b1;
            end
            K_ALT1: begin
               nxt_b      = 1'b0;
               nxt_alt[0] = 1'b1;
            end
            K_ALT2: begin
               nxt_b      = 1'b0;
               nxt_alt[1] = 1'b1;
            end
            K_ALT3: begin
               nxt_b   = 1'b0;
               nxt_alt = '1;
            end
            K_TO: begin
               if (cur_b) begin
                  mv_req_c = 1'b1;
                  mv_src_c = cur_src;
                  mv_dst_c = reg_field;
                  nxt_src  = IDLE_IDX;
                  nxt_dst  = IDLE_IDX;
                  nxt_b    = 1'b0;
                  nxt_alt  = '0;
               end else begin
                  nxt_dst = reg_field;
               end
            end
            K_FROM: begin
               if (cur_b) begin
                  mv_req_c   = 1'b1;
                  mv_src_c   = reg_field;
                  mv_dst_c   = cur_dst;
                  mv_flags_c = 1'b1;
                  nxt_src    = IDLE_IDX;
                  nxt_dst    = IDLE_IDX;
                  nxt_b      = 1'b0;
                  nxt_alt    = '0;
               end else begin
                  nxt_src = reg_field;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pfx_state.sv
module pfx_state
   import pfx_pkg::*;
#(
   parameter int IDX_W   = 4,
   parameter int CLR_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] nxt_src,
   input  logic [IDX_W-1:0] nxt_dst,
   input  logic             nxt_b,
   input  logic [ALT_W-1:0] nxt_alt,
   output logic [IDX_W-1:0] cur_src,
   output logic [IDX_W-1:0] cur_dst,
   output logic             cur_b,
   output logic [ALT_W-1:0] cur_alt
);
   localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(CLR_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_src <= IDLE_IDX;
         cur_dst <= IDLE_IDX;
         cur_b   <= 1'b0;
         cur_alt <= '0;
      end else begin
         cur_src <= nxt_src;
         cur_dst <= nxt_dst;
         cur_b   <= nxt_b;
         cur_alt <= nxt_alt;
      end
   end
endmodule

// File: rtl/pfx_move_out.sv
module pfx_move_out #(
   parameter int IDX_W    = 4,
   parameter bit MOVE_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_c,
   input  logic [IDX_W-1:0] src_c,
   input  logic [IDX_W-1:0] dst_c,
   input  logic             flags_c,
   output logic             req_o,
   output logic [IDX_W-1:0] src_o,
   output logic [IDX_W-1:0] dst_o,
   output logic             flags_o
);
   generate
      if (MOVE_REG) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_o   <= 1'b0;
               src_o   <= '0;
               dst_o   <= '0;
               flags_o <= 1'b0;
            end else begin
               req_o   <= req_c;
               src_o   <= src_c;
               dst_o   <= dst_c;
               flags_o <= flags_c;
            end
         end
      end else begin : g_comb
         assign req_o   = req_c;
         assign src_o   = src_c;
         assign dst_o   = dst_c;
         assign flags_o = flags_c;
      end
   endgenerate
endmodule

// File: rtl/pfx_select_ctrl.sv
module pfx_select_ctrl
   import pfx_pkg::*;
#(
   parameter int IDX_W    = 4,
   parameter int CLR_IDX  = 0,
   parameter bit MOVE_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [2:0]       op_kind,
   input  logic [IDX_W-1:0] reg_field,
   input  logic             op_done,
   output logic [IDX_W-1:0] src_idx,
   output logic [IDX_W-1:0] dst_idx,
   output logic             b_flag,
   output logic [1:0]       alt_mode,
   output logic             mv_req,
   output logic [IDX_W-1:0] mv_src,
   output logic [IDX_W-1:0] mv_dst,
   output logic             mv_flags
);
   localparam int NUM_REGS = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_width
         $error("pfx_select_ctrl: IDX_W out of range");
      end
      if (CLR_IDX < 0 || CLR_IDX >= NUM_REGS) begin : g_bad_clr
         $error("pfx_select_ctrl: CLR_IDX outside register file");
      end
   endgenerate

   logic [IDX_W-1:0] nxt_src, nxt_dst, mv_src_c, mv_dst_c;
   logic             nxt_b, mv_req_c, mv_flags_c;
   logic [ALT_W-1:0] nxt_alt;

   pfx_next #(.IDX_W(IDX_W), .CLR_IDX(CLR_IDX)) u_next (
      .cur_src(src_idx), .cur_dst(dst_idx), .cur_b(b_flag), .cur_alt(alt_mode),
      .op_valid(op_valid), .op_kind(op_kind), .reg_field(reg_field), .op_done(op_done),
      .nxt_src(nxt_src), .nxt_dst(nxt_dst), .nxt_b(nxt_b), .nxt_alt(nxt_alt),
      .mv_req_c(mv_req_c), .mv_src_c(mv_src_c), .mv_dst_c(mv_dst_c), .mv_flags_c(mv_flags_c)
   );

   pfx_state #(.IDX_W(IDX_W), .CLR_IDX(CLR_IDX)) u_state (
      .clk(clk), .rst_n(rst_n),
      .nxt_src(nxt_src), .nxt_dst(nxt_dst), .nxt_b(nxt_b), .nxt_alt(nxt_alt),
      .cur_src(src_idx), .cur_dst(dst_idx), .cur_b(b_flag), .cur_alt(alt_mode)
   );

   pfx_move_out #(.IDX_W(IDX_W), .MOVE_REG(MOVE_REG)) u_move (
      .clk(clk), .rst_n(rst_n),
      .req_c(mv_req_c), .src_c(mv_src_c), .dst_c(mv_dst_c), .flags_c(mv_flags_c),
      .req_o(mv_req), .src_o(mv_src), .dst_o(mv_dst), .flags_o(mv_flags)
   );
endmodule

// File: rtl/pfx_select_chk.sv
module pfx_select_chk #(
   parameter int IDX_W    = 4,
   parameter int CLR_IDX  = 0,
   parameter bit MOVE_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [2:0]       op_kind,
   input logic [IDX_W-1:0] reg_field,
   input logic             op_done,
   input logic [IDX_W-1:0] src_idx,
   input logic [IDX_W-1:0] dst_idx,
   input logic             b_flag,
   input logic [1:0]       alt_mode,
   input logic             mv_req
);
   localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(CLR_IDX);

   // R9
   done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_done |=> (src_idx == IDLE_IDX && dst_idx == IDLE_IDX && !b_flag && alt_mode == 2'b00));

   // R2
   with_sets_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_done && op_kind == 3'd1)
      |=> (src_idx == $past(reg_field) && dst_idx == $past(reg_field) && b_flag));

   // R3
   alt_drops_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_done && (op_kind == 3'd2 || op_kind == 3'd3 || op_kind == 3'd4))
      |=> (!b_flag && $stable(src_idx) && $stable(dst_idx)));

   // R8
   branch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_done && (op_kind == 3'd7 || op_kind == 3'd0))
      |=> ($stable(src_idx) && $stable(dst_idx) && $stable(b_flag) && $stable(alt_mode)));

   generate
      if (!MOVE_REG) begin : g_comb_move
         // R11
         mv_needs_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mv_req |-> (b_flag && op_valid && !op_done));

         // R5
         mv_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mv_req |=> (!b_flag && alt_mode == 2'b00 && src_idx == IDLE_IDX));
      end
   endgenerate
endmodule

bind pfx_select_ctrl pfx_select_chk #(.IDX_W(IDX_W), .CLR_IDX(CLR_IDX), .MOVE_REG(MOVE_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .reg_field(reg_field),
   .op_done(op_done), .src_idx(src_idx), .dst_idx(dst_idx), .b_flag(b_flag),
   .alt_mode(alt_mode), .mv_req(mv_req)
);

// File: tb/pfx_select_ctrl_tb_top.sv
`timescale 1ns/1ps
module pfx_select_ctrl_tb_top;
   localparam int IDX_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             op_valid = 1'b0;
   logic [2:0]       op_kind = 3'd0;
   logic [IDX_W-1:0] reg_field = '0;
   logic             op_done = 1'b0;
   logic [IDX_W-1:0] src_idx, dst_idx, mv_src, mv_dst;
   logic             b_flag, mv_req, mv_flags;
   logic [1:0]       alt_mode;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // reference model state
   logic [IDX_W-1:0] m_src = '0, m_dst = '0;
   logic             m_b = 1'b0;
   logic [1:0]       m_alt = 2'b00;

   always #10 clk = ~clk;

   pfx_select_ctrl #(.IDX_W(IDX_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .reg_field(reg_field), .op_done(op_done), .src_idx(src_idx), .dst_idx(dst_idx),
      .b_flag(b_flag), .alt_mode(alt_mode), .mv_req(mv_req), .mv_src(mv_src),
      .mv_dst(mv_dst), .mv_flags(mv_flags)
   );

   function automatic string tag_for(logic v, logic [2:0] k, logic d, logic b);
      if (d) return (v && k != 3'd0) ? "R10" : "R9";
      if (!v) return "R8";
      case (k)
         3'd1: return "R2";
         3'd2, 3'd3, 3'd4: return "R3";
         3'd5: return b ? "R5" : "R4";
         3'd6: return b ? "R7" : "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check moves, clock, update model, check state
   task automatic step(logic v, logic [2:0] k, logic [IDX_W-1:0] f, logic d);
      logic             e_mv, e_fl;
      logic [IDX_W-1:0] e_ms, e_md;
      string            t;
      op_valid = v; op_kind = k; reg_field = f; op_done = d;
      #1;
      e_mv = v && !d && m_b && (k == 3'd5 || k == 3'd6);
      e_ms = (k == 3'd5) ? m_src : f;
      e_md = (k == 3'd5) ? f : m_dst;
      e_fl = (k == 3'd6);
      t = tag_for(v, k, d, m_b);
      if (e_mv) check(t, {mv_req, mv_flags, mv_src, mv_dst}, {e_mv, e_fl, e_ms, e_md});
      else check((d && v) ? "R10" : "R11", {31'd0, mv_req}, 32'd0);
      if (d) begin m_src = '0; m_dst = '0; m_b = 0; m_alt = 0; end
      else if (v) begin
         case (k)
            3'd1: begin m_src = f; m_dst = f; m_b = 1; end
            3'd2: begin m_b = 0; m_alt[0] = 1; end
            3'd3: begin m_b = 0; m_alt[1] = 1; end
            3'd4: begin m_b = 0; m_alt = 2'b11; end
            3'd5: if (m_b) begin m_src = '0; m_dst = '0; m_b = 0; m_alt = 0; end
                  else m_dst = f;
            3'd6: if (m_b) begin m_src = '0; m_dst = '0; m_b = 0; m_alt = 0; end
                  else m_src = f;
            default: ;
         endcase
      end
      @(negedge clk);
      check(t, {src_idx, dst_idx, b_flag, alt_mode}, {m_src, m_dst, m_b, m_alt});
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (2) @(negedge clk);
      check("R1", {src_idx, dst_idx, b_flag, alt_mode}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {src_idx, dst_idx, b_flag, alt_mode}, '0);
      // directed: pair select then destination move
      step(1, 3'd1, 4'd5, 0);
      step(1, 3'd5, 4'd9, 0);   // R5 move 5 -> 9
      // pair select then source move with flags
      step(1, 3'd1, 4'd3, 0);
      step(1, 3'd6, 4'd12, 0);  // R7 move 12 -> 3
      // chained prefixes: variant bits accumulate, later select overrides
      step(1, 3'd2, 4'd0, 0);
      step(1, 3'd1, 4'd7, 0);
      step(1, 3'd3, 4'd0, 0);   // R3 b dropped, alt 11
      step(1, 3'd5, 4'd14, 0);  // R4 dst only
      step(1, 3'd6, 4'd2, 0);   // R6 src only
      step(1, 3'd7, 4'd1, 0);   // R8 branch holds
      step(0, 3'd0, 4'd0, 0);   // R8 idle
      step(1, 3'd1, 4'd8, 0);
      step(1, 3'd5, 4'd4, 1);   // R10 done wins over move
      step(1, 3'd4, 4'd0, 0);
      step(0, 3'd0, 4'd0, 1);   // R9 clear
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic v, d;
         logic [2:0] k;
         v = ($urandom % 8) != 0;
         d = ($urandom % 7) == 0;
         k = 3'($urandom % 8);
         step(v, k, 4'($urandom), d);
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule